// File: doc/BRIEF.md
# Audio Port Interrupt Register Bank

This block collects event pulses from a multi-channel audio serial port and turns them into one interrupt request. Per-channel events (transmit ready, transmit underrun, receive ready, receive overflow) for up to eight channels land in a first register group. Shared FIFO and error events land in a second group. Each event sets a sticky status bit. Software reads a status register to collect the bits, and reading it clears them.

Each group has its own interrupt mask. Software never writes the mask directly. It writes ones to a set register to enable sources and ones to a clear register to disable them, so drivers on different threads can change their own bits without a read-modify-write. The mask itself can only be read. The interrupt line goes high one cycle after any source has both its mask bit and its status bit set.

Access is through a simple 32-bit register port with byte addresses. A read returns its data on the clock edge that accepts it, so the data is valid in the following cycle. The data stays on `rdata_o` until the next read.

Top module: `aud_irq_bank`

## Requirements
- R1: After reset, both masks and both status registers are zero, `irq_o` is 0 and `rdata_o` is 0.
- R2: A write to a group's set register (group 1 at 0x10, group 2 at 0x20) ORs the implemented bits of the written word into that group's mask. Zero bits leave their mask bits unchanged. The mask reads back at base+0x8.
- R3: A write to a group's clear register (base+0x4) clears every mask bit where the written word has a one. Other mask bits are kept.
- R4: Group 1 status (0x1C) holds transmit-ready of channel n at bit n, transmit underrun at bit 8+n, receive-ready at bit 16+n and receive overflow at bit 24+n.
- R5: Group 2 status (0x2C) holds write error at bit 0, transmit FIFO ready at bit 8, transmit FIFO empty at bit 9, receive FIFO ready at bit 12 and receive FIFO full at bit 13. All other group 2 bits read as 0 in both the mask and the status, and can never be set.
- R6: Status bits are sticky. A read of a status register returns the bits held before the read and clears them on the same edge. The read data appears on `rdata_o` in the cycle after `rd_en_i` is sampled high.
- R7: An event that arrives in the same cycle as the read that clears its status register is kept, and is returned by the next read.
- R8: `irq_o` is high in the cycle after any group has a bit set in both its mask and its status. It is low in the cycle after no such bit exists.
- R9: Writes to a mask or status register, to unmapped addresses, or to addresses that are not word-aligned change nothing. Reads of set, clear, unmapped or unaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| tx_rdy_evt_i | input | 8 | Per-channel transmit-ready pulses |
| tx_unf_evt_i | input | 8 | Per-channel transmit-underrun pulses |
| rx_rdy_evt_i | input | 8 | Per-channel receive-ready pulses |
| rx_ovf_evt_i | input | 8 | Per-channel receive-overflow pulses |
| wr_err_evt_i | input | 1 | Write-error pulse |
| txf_rdy_evt_i | input | 1 | Transmit FIFO ready pulse |
| txf_emp_evt_i | input | 1 | Transmit FIFO empty pulse |
| rxf_rdy_evt_i | input | 1 | Receive FIFO ready pulse |
| rxf_ful_evt_i | input | 1 | Receive FIFO full pulse |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The assertions assume that each register access is a single-cycle strobe and that one address is presented per cycle. A write and a read are not presented in the same cycle. Event inputs may pulse in any cycle, on any number of channels at once, including the cycle of a clearing read. The stimulus only ever asserts one strobe per cycle. It mixes aligned, unaligned and unmapped addresses, and fires sparse random event bursts so that masked and unmasked sources, simultaneous set and read-clear, and idle stretches all occur.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int DW = 32;

  // register select within a group, from addr[3:2]
  localparam logic [1:0] SEL_SET = 2'd0;
  localparam logic [1:0] SEL_CLR = 2'd1;
  localparam logic [1:0] SEL_MSK = 2'd2;
  localparam logic [1:0] SEL_STS = 2'd3;

  localparam int B_WERR    = 0;
  localparam int B_TXF_RDY = 8;
  localparam int B_TXF_EMP = 9;
  localparam int B_RXF_RDY = 12;
  localparam int B_RXF_FUL = 13;

  localparam logic [DW-1:0] B_VALID = (DW'(1) << B_WERR)    | (DW'(1) << B_TXF_RDY) |
                                      (DW'(1) << B_TXF_EMP) | (DW'(1) << B_RXF_RDY) |
                                      (DW'(1) << B_RXF_FUL);

  // implemented bits of the lane group: low nch bits of each of four lanes
  function automatic logic [DW-1:0] lane_valid(input int nch, input int lane);
    logic [DW-1:0] v;
    v = '0;
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < nch; c++)
        v[l*lane + c] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/aud_irq_grp.sv
module aud_irq_grp
  import aud_irq_pkg::*;
#(
  parameter logic [DW-1:0] VALID = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_we_i,
  input  logic          clr_we_i,
  input  logic          sts_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] status_o,
  output logic          pend_o
);
  logic [DW-1:0] mask_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (set_we_i) begin
      mask_q <= mask_q | (wdata_i & VALID);
    end else if (clr_we_i) begin
      mask_q <= mask_q & ~wdata_i;
    end
  end

  // read-clear and new events resolved together: events win
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= ((sts_rd_i ? '0 : sts_q) | evt_i) & VALID;
  end

  assign mask_o   = mask_q;
  assign status_o = sts_q;
  assign pend_o   = |(mask_q & sts_q);

  // R2
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((mask_o & $past(wdata_i & VALID)) == $past(wdata_i & VALID)));

  // R3
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((mask_o & $past(wdata_i)) == '0));

  // R7
  evt_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_rd_i |=> ((status_o & $past(evt_i & VALID)) == $past(evt_i & VALID)));

  // R6
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_rd_i && evt_i == '0) |=> (status_o == '0));

  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_rd_i |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/aud_irq_bank.sv
module aud_irq_bank
  import aud_irq_pkg::*;
#(
  parameter int          NCH    = 8,
  parameter int          AW     = 8,
  parameter logic [7:0]  BASE_A = 8'h10,
  parameter logic [7:0]  BASE_B = 8'h20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] tx_rdy_evt_i,
  input  logic [NCH-1:0] tx_unf_evt_i,
  input  logic [NCH-1:0] rx_rdy_evt_i,
  input  logic [NCH-1:0] rx_ovf_evt_i,
  input  logic           wr_err_evt_i,
  input  logic           txf_rdy_evt_i,
  input  logic           txf_emp_evt_i,
  input  logic           rxf_rdy_evt_i,
  input  logic           rxf_ful_evt_i,
  output logic           irq_o
);
  localparam int NGRP = 2;
  localparam int LANE = DW / 4;
  localparam logic [DW-1:0] A_VALID = lane_valid(NCH, LANE);
  localparam logic [AW-1:0] BASES [NGRP] = '{AW'(BASE_A), AW'(BASE_B)};
  localparam logic [DW-1:0] VALIDS[NGRP] = '{A_VALID, B_VALID};

  logic [NGRP-1:0][DW-1:0] evt, msk, sts;
  logic [NGRP-1:0]         hit, pend;
  logic [1:0]              sel;
  logic                    aligned;

  assign evt[0] = {LANE'(rx_ovf_evt_i), LANE'(rx_rdy_evt_i),
                   LANE'(tx_unf_evt_i), LANE'(tx_rdy_evt_i)};

  always_comb begin
    evt[1]            = '0;
    evt[1][B_WERR]    = wr_err_evt_i;
    evt[1][B_TXF_RDY] = txf_rdy_evt_i;
    evt[1][B_TXF_EMP] = txf_emp_evt_i;
    evt[1][B_RXF_RDY] = rxf_rdy_evt_i;
    evt[1][B_RXF_FUL] = rxf_ful_evt_i;
  end

  assign sel     = addr_i[3:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign hit[g] = aligned && (addr_i[AW-1:4] == BASES[g][AW-1:4]);

    aud_irq_grp #(.VALID(VALIDS[g])) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_we_i (wr_en_i && hit[g] && sel == SEL_SET),
      .clr_we_i (wr_en_i && hit[g] && sel == SEL_CLR),
      .sts_rd_i (rd_en_i && hit[g] && sel == SEL_STS),
      .wdata_i  (wdata_i),
      .evt_i    (evt[g]),
      .mask_o   (msk[g]),
      .status_o (sts[g]),
      .pend_o   (pend[g])
    );
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (hit[g] && sel == SEL_MSK) rd_mux = msk[g];
      if (hit[g] && sel == SEL_STS) rd_mux = sts[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend;
  end

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|((msk[0] & sts[0]) | (msk[1] & sts[1]))));

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|((msk[0] & sts[0]) | (msk[1] & sts[1]))) |=> irq_o);

  // R5
  b_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((msk[1] | sts[1]) & ~B_VALID) == '0);
endmodule

// File: tb/tb_aud_irq_bank.sv
module tb_aud_irq_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  tx_rdy = 0, tx_unf = 0, rx_rdy = 0, rx_ovf = 0;
  logic        werr = 0, tfr = 0, tfe = 0, rfr = 0, rff = 0;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_irq_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tx_rdy_evt_i(tx_rdy), .tx_unf_evt_i(tx_unf),
    .rx_rdy_evt_i(rx_rdy), .rx_ovf_evt_i(rx_ovf),
    .wr_err_evt_i(werr), .txf_rdy_evt_i(tfr), .txf_emp_evt_i(tfe),
    .rxf_rdy_evt_i(rfr), .rxf_ful_evt_i(rff), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ma, m_sa, m_mb, m_sb, m_rd;
  logic        m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ma = 0; m_sa = 0; m_mb = 0; m_sb = 0; m_rd = 0; m_irq = 0;
    end else begin
      logic [31:0] ea, eb;
      m_irq = ((m_ma & m_sa) != 0) || ((m_mb & m_sb) != 0);
      if (rd_en) begin
        case (addr)
          8'h18:   m_rd = m_ma;
          8'h1C:   m_rd = m_sa;
          8'h28:   m_rd = m_mb;
          8'h2C:   m_rd = m_sb;
          default: m_rd = 0;
        endcase
      end
      ea = {rx_ovf, rx_rdy, tx_unf, tx_rdy};
      eb = 0;
      eb[0] = werr; eb[8] = tfr; eb[9] = tfe; eb[12] = rfr; eb[13] = rff;
      m_sa = ((rd_en && addr == 8'h1C) ? 32'h0 : m_sa) | ea;
      m_sb = ((rd_en && addr == 8'h2C) ? 32'h0 : m_sb) | eb;
      if (wr_en && addr == 8'h10) m_ma = m_ma | wdata;
      if (wr_en && addr == 8'h14) m_ma = m_ma & ~wdata;
      if (wr_en && addr == 8'h20) m_mb = m_mb | (wdata & 32'h0000_3301);
      if (wr_en && addr == 8'h24) m_mb = m_mb & ~wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 rdata vs model", rdata, m_rd);
      check("R8 irq vs model", {31'b0, irq}, {31'b0, m_irq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    check(req, rdata, exp);
  endtask

  task automatic clr_evts();
    tx_rdy = 0; tx_unf = 0; rx_rdy = 0; rx_ovf = 0;
    werr = 0; tfr = 0; tfe = 0; rfr = 0; rff = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 rdata after reset", rdata, 0);
    check("R1 irq after reset", {31'b0, irq}, 0);
    rd_chk(8'h18, 0, "R1 mask A reset");
    rd_chk(8'h1C, 0, "R1 status A reset");
    rd_chk(8'h28, 0, "R1 mask B reset");
    rd_chk(8'h2C, 0, "R1 status B reset");

    // R2 set, R3 clear
    wr(8'h10, 32'h0000_00FF);
    rd_chk(8'h18, 32'h0000_00FF, "R2 set mask A");
    wr(8'h10, 32'h0000_0F00);
    rd_chk(8'h18, 32'h0000_0FFF, "R2 zeros keep mask");
    wr(8'h14, 32'h0000_000F);
    rd_chk(8'h18, 32'h0000_0FF0, "R3 clear mask A");

    // R4/R8 masked event raises irq; read clears it (R6)
    @(negedge clk); tx_rdy = 8'h10;
    @(negedge clk); clr_evts();
    @(negedge clk);
    check("R8 irq raised", {31'b0, irq}, 1);
    rd_chk(8'h1C, 32'h0000_0010, "R4 tx ready ch4 bit4");
    rd_chk(8'h1C, 32'h0, "R6 status cleared by read");
    @(negedge clk);
    check("R8 irq dropped", {31'b0, irq}, 0);

    // R4 lane layout
    @(negedge clk); tx_unf = 8'h04; rx_rdy = 8'h80; rx_ovf = 8'h01;
    @(negedge clk); clr_evts();
    rd_chk(8'h1C, 32'h0180_0400, "R4 lanes unf/rxrdy/ovf");

    // R5 group B layout and reserved bits
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h28, 32'h0000_3301, "R5 mask B implemented bits");
    @(negedge clk); werr = 1; tfr = 1; tfe = 1; rfr = 1; rff = 1;
    @(negedge clk); clr_evts();
    rd_chk(8'h2C, 32'h0000_3301, "R5 status B layout");
    wr(8'h24, 32'hFFFF_FFFF);

    // R7 event during clearing read
    @(negedge clk); tx_rdy = 8'h01;
    @(negedge clk); clr_evts(); rd_en = 1; addr = 8'h1C; rx_ovf = 8'h08;
    @(negedge clk); rd_en = 0; clr_evts();
    check("R7 read returns earlier bits", rdata, 32'h0000_0001);
    rd_chk(8'h1C, 32'h0800_0000, "R7 same-cycle event kept");

    // R9 ignored writes and zero reads
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rd_chk(8'h18, 32'h0000_0FF0, "R9 mask A unchanged");
    rd_chk(8'h1C, 32'h0, "R9 status A unchanged");
    rd_chk(8'h28, 32'h0, "R9 mask B unchanged");
    rd_chk(8'h10, 32'h0, "R9 set reg reads zero");
    rd_chk(8'h24, 32'h0, "R9 clear reg reads zero");
    rd_chk(8'h19, 32'h0, "R9 unaligned reads zero");

    // random phase, compared per cycle against model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      begin
        int op;
        logic [7:0] al [10] = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                                8'h24, 8'h28, 8'h2C, 8'h30, 8'h1E};
        op = $urandom_range(0, 3);
        wr_en = (op == 1); rd_en = (op == 2);
        addr = al[$urandom_range(0, 9)];
        wdata = $urandom;
        tx_rdy = 8'($urandom & $urandom & $urandom);
        tx_unf = 8'($urandom & $urandom & $urandom);
        rx_rdy = 8'($urandom & $urandom & $urandom);
        rx_ovf = 8'($urandom & $urandom & $urandom);
        werr = ($urandom_range(0, 7) == 0); tfr = ($urandom_range(0, 7) == 0);
        tfe = ($urandom_range(0, 7) == 0);  rfr = ($urandom_range(0, 7) == 0);
        rff = ($urandom_range(0, 7) == 0);
      end
    end
    @(negedge clk); wr_en = 0; rd_en = 0; clr_evts();
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule